// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Slave

This block is a two-wire serial bus slave that owns an eight-entry byte-wide configuration file. The file controls a small set of clock-output features: four per-output enables, a software mode override with a two-bit mode field, a two-bit output amplitude, four per-output slew selects and one feedback slew select. The serial clock and data lines are open-drain. Both lines are brought into the system clock domain through synchronizers and are oversampled. The slave pulls data low through an enable and never drives it high.

Every host write names a start index, then a byte count, then the data. Every host read first sets the index with a write-direction header. After a repeated START the slave returns a count byte, then consecutive registers. The number of data bytes in a read is set by a writable count register, not only by the host's final NACK. The 7-bit slave address is one of three values. A 2-bit strap picks the value, and the address is frozen on the first rising edge of power-good. While the reference-clock-running input is low, the slave ignores the bus.

Top module: `smb_cfg_slave`

## Requirements
- R1: The strap is captured on the first rising edge of `pwrgd_i` after reset: 00 selects address 0x6B, 01 selects 0x6C, and 10 or 11 selects 0x6D. Later strap changes and later power-good edges do not alter the address. Before capture, and for any other address, the address byte gets no ACK.
- R2: A write of the form address+W, index N, count X, data bytes gets an ACK for every byte. The first X data bytes go to registers N, N+1, and so on.
- R3: Data bytes sent after the first X of a write get an ACK and change no register.
- R4: A read (address+W, index N, repeated START, address+R) returns a count byte, then register N, N+1, and so on. The host ACKs each byte and NACKs the last one.
- R5: The count byte equals register 7 bits [4:0]. Exactly that many data bytes follow. Any byte after them reads 0xFF because the slave releases the line. After the host's NACK the slave drives nothing.
- R6: Register 7 holds the read count in bits [4:0], with reset value 8. Bits [7:5] read 0.
- R7: Register 0 holds the four output enables at bits 6, 5, 3 and 1, mapped to `out_en_o[3..0]`. They reset to 1. Bits 7, 4, 2 and 0 always read 1.
- R8: Register 1 reads `mode_rb_i` at bits [7:6], the software-mode enable at bit 5 (reset 0), the mode control at bits [4:3] (reset 00), 0 at bit 2, and the amplitude at bits [1:0]. The amplitude codes are 00=0.55 V, 01=0.65 V, 10=0.75 V and 11=0.85 V, with reset 10. Writes to bits [7:6] are ignored.
- R9: Register 2 holds the slew selects at bits 6, 5, 3 and 1 (1 = fast, reset 1), mapped to `slew_o[3..0]`. Its other bits read 1. Register 3 bit 0 is the feedback slew (reset 1), and its other bits read 0.
- R10: Register 4 reads 0xFF, register 5 reads 0x01 and register 6 reads 0x44. Writes to them get an ACK and have no effect.
- R11: Indices above 7 read 0x00, and writes to them are ignored. The pointer saturates and does not wrap back to 0.
- R12: While `ref_run_i` is low the slave gives no ACK and does not drive the data line.
- R13: The configuration outputs and `sda_oe_o` change only after an edge on the bus lines. A read leaves every configuration output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwrgd_i | input | 1 | Power-good; its first rise captures the address strap |
| strap_i | input | 2 | Address strap code (00 low, 01 mid, 1x high) |
| ref_run_i | input | 1 | High while the reference clock runs |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| mode_rb_i | input | 2 | Mode readback shown in register 1 [7:6] |
| out_en_o | output | 4 | Per-output enables |
| sw_mode_o | output | 1 | Software mode override enable |
| mode_ctl_o | output | 2 | Software mode field |
| amp_o | output | 2 | Output amplitude code |
| slew_o | output | 4 | Per-output slew selects, 1 = fast |
| fb_slew_o | output | 1 | Feedback slew select |

## Verification
The bench builds the block with its default parameters: the three default addresses and a two-flop synchronizer. It drives the bus with a bit period of twelve system clocks, so every edge clears the synchronizer with margin. Because the five-bit count field can be set above eight, reads run past the end of the file into the zero region and then past the count into the released 0xFF region. Random writes land on writable, read-only and out-of-range indices. Reset is also applied with each strap code to reach all three addresses.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int unsigned REG_N     = 8;
  localparam int unsigned CNT_W     = 5;
  localparam logic [7:0]  RSVD_VAL  = 8'hFF;
  localparam logic [7:0]  ID_REV    = 8'h01;
  localparam logic [7:0]  ID_TYPE   = 8'h44;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_INDEX, PH_COUNT, PH_WDATA, PH_TX, PH_SKIP
  } phase_e;

  typedef struct packed {
    logic [3:0]       out_en;
    logic             sw_mode;
    logic [1:0]       mode_ctl;
    logic [1:0]       amp;
    logic [3:0]       slew;
    logic             fb_slew;
    logic [CNT_W-1:0] rd_cnt;
  } cfg_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_line
    // pipe[0] newest, pipe[STAGES-1] synced, pipe[STAGES] previous synced
    logic [STAGES:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;
      else         pipe <= {pipe[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_cfg_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_idx_i,
  input  logic [1:0] mode_rb_i,
  output logic [7:0] rd_data_o,
  output cfg_t       cfg_o
);
  logic unused_bits;
  assign unused_bits = ^{wr_data_i[7], wr_data_i[2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o.out_en   <= '1;
      cfg_o.sw_mode  <= 1'b0;
      cfg_o.mode_ctl <= 2'b00;
      cfg_o.amp      <= 2'b10;
      cfg_o.slew     <= '1;
      cfg_o.fb_slew  <= 1'b1;
      cfg_o.rd_cnt   <= CNT_W'(REG_N);
    end else if (wr_en_i) begin
      unique case (wr_idx_i)
        8'd0: cfg_o.out_en <= {wr_data_i[6], wr_data_i[5], wr_data_i[3], wr_data_i[1]};
        8'd1: begin
          cfg_o.sw_mode  <= wr_data_i[5];
          cfg_o.mode_ctl <= wr_data_i[4:3];
          cfg_o.amp      <= wr_data_i[1:0];
        end
        8'd2: cfg_o.slew    <= {wr_data_i[6], wr_data_i[5], wr_data_i[3], wr_data_i[1]};
        8'd3: cfg_o.fb_slew <= wr_data_i[0];
        8'd7: cfg_o.rd_cnt  <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_idx_i)
      8'd0: rd_data_o = {1'b1, cfg_o.out_en[3], cfg_o.out_en[2], 1'b1,
                         cfg_o.out_en[1], 1'b1, cfg_o.out_en[0], 1'b1};
      8'd1: rd_data_o = {mode_rb_i, cfg_o.sw_mode, cfg_o.mode_ctl, 1'b0, cfg_o.amp};
      8'd2: rd_data_o = {1'b1, cfg_o.slew[3], cfg_o.slew[2], 1'b1,
                         cfg_o.slew[1], 1'b1, cfg_o.slew[0], 1'b1};
      8'd3: rd_data_o = {7'd0, cfg_o.fb_slew};
      8'd4: rd_data_o = RSVD_VAL;
      8'd5: rd_data_o = ID_REV;
      8'd6: rd_data_o = ID_TYPE;
      8'd7: rd_data_o = {{(8-CNT_W){1'b0}}, cfg_o.rd_cnt};
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/smb_link.sv
module smb_link import smb_cfg_pkg::*; #(
  parameter logic [6:0] ADDR_LO  = 7'h6B,
  parameter logic [6:0] ADDR_MID = 7'h6C,
  parameter logic [6:0] ADDR_HI  = 7'h6D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwrgd_i,
  input  logic [1:0]       strap_i,
  input  logic             ref_run_i,
  input  logic             scl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             sda_rise_i,
  input  logic             sda_fall_i,
  input  logic [7:0]       rd_data_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  output logic [7:0]       rd_idx_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic             in_ack, ack_drv, host_nack;
  logic [7:0]       shreg, tx_sh, idx, wr_left;
  logic [CNT_W-1:0] tx_left;
  logic             pg_q, addr_ok;
  logic [6:0]       my_addr, strap_addr;
  logic             start, stop;
  logic [7:0]       nxt_idx;

  assign start   = sda_fall_i & scl_i;
  assign stop    = sda_rise_i & scl_i;
  assign nxt_idx = (idx < 8'(REG_N)) ? idx + 8'd1 : idx;  // saturate, no wrap
  assign rd_idx_o = idx;

  always_comb begin
    unique case (strap_i)
      2'b00:   strap_addr = ADDR_LO;
      2'b01:   strap_addr = ADDR_MID;
      default: strap_addr = ADDR_HI;
    endcase
  end

  assign sda_oe_o = (in_ack & ack_drv) | ((phase == PH_TX) & ~in_ack & ~tx_sh[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q <= 1'b0; addr_ok <= 1'b0; my_addr <= '0;
      phase <= PH_IDLE; bit_cnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
      host_nack <= 1'b0; shreg <= '0; tx_sh <= '1; idx <= '0;
      wr_left <= '0; tx_left <= '0;
      wr_en_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      pg_q    <= pwrgd_i;
      wr_en_o <= 1'b0;
      if (pwrgd_i && !pg_q && !addr_ok) begin
        addr_ok <= 1'b1;
        my_addr <= strap_addr;
      end
      if (!ref_run_i || stop) begin
        phase <= PH_IDLE; bit_cnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
      end else if (start) begin
        phase <= PH_ADDR; bit_cnt <= '0; in_ack <= 1'b0; ack_drv <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
        if (scl_rise_i) begin
          if (in_ack) host_nack <= sda_i;
          else if (bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall_i) begin
          if (in_ack) begin
            in_ack <= 1'b0; ack_drv <= 1'b0; bit_cnt <= '0;
            unique case (phase)
              PH_ADDR: begin
                if (!ack_drv) phase <= PH_SKIP;
                else if (shreg[0]) begin
                  phase   <= PH_TX;
                  tx_sh   <= {{(8-CNT_W){1'b0}}, rd_cnt_i};
                  tx_left <= rd_cnt_i;
                end else phase <= PH_INDEX;
              end
              PH_INDEX: begin idx <= shreg; phase <= PH_COUNT; end
              PH_COUNT: begin wr_left <= shreg; phase <= PH_WDATA; end
              PH_TX: begin
                if (host_nack) phase <= PH_SKIP;
                else if (tx_left != '0) begin
                  tx_sh   <= rd_data_i;
                  tx_left <= tx_left - 1'b1;
                  idx     <= nxt_idx;
                end else tx_sh <= 8'hFF;  // past count: line released
              end
              default: ;
            endcase
          end else if (bit_cnt == 4'd8) begin
            in_ack <= 1'b1;
            unique case (phase)
              PH_ADDR: ack_drv <= addr_ok && (shreg[7:1] == my_addr);
              PH_TX:   ack_drv <= 1'b0;
              PH_WDATA: begin
                ack_drv <= 1'b1;
                if (wr_left != '0) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx;
                  wr_data_o <= shreg;
                  wr_left   <= wr_left - 8'd1;
                  idx       <= nxt_idx;
                end
              end
              default: ack_drv <= 1'b1;
            endcase
          end else if (phase == PH_TX && bit_cnt != '0) begin
            tx_sh <= {tx_sh[6:0], 1'b1};
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave import smb_cfg_pkg::*; #(
  parameter logic [6:0]  ADDR_LO     = 7'h6B,
  parameter logic [6:0]  ADDR_MID    = 7'h6C,
  parameter logic [6:0]  ADDR_HI     = 7'h6D,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwrgd_i,
  input  logic [1:0] strap_i,
  input  logic       ref_run_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] mode_rb_i,
  output logic [3:0] out_en_o,
  output logic       sw_mode_o,
  output logic [1:0] mode_ctl_o,
  output logic [1:0] amp_o,
  output logic [3:0] slew_o,
  output logic       fb_slew_o
);
  logic [1:0] lvl, rise, fall;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
  cfg_t       cfg;

  smb_line_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  smb_link #(.ADDR_LO(ADDR_LO), .ADDR_MID(ADDR_MID), .ADDR_HI(ADDR_HI)) i_link (
    .clk_i, .rst_ni, .pwrgd_i, .strap_i, .ref_run_i,
    .scl_i(lvl[0]), .scl_rise_i(rise[0]), .scl_fall_i(fall[0]),
    .sda_i(lvl[1]), .sda_rise_i(rise[1]), .sda_fall_i(fall[1]),
    .rd_data_i(rd_data), .rd_cnt_i(cfg.rd_cnt), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .sda_oe_o
  );

  smb_regfile i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .mode_rb_i, .rd_data_o(rd_data), .cfg_o(cfg)
  );

  assign out_en_o   = cfg.out_en;
  assign sw_mode_o  = cfg.sw_mode;
  assign mode_ctl_o = cfg.mode_ctl;
  assign amp_o      = cfg.amp;
  assign slew_o     = cfg.slew;
  assign fb_slew_o  = cfg.fb_slew;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrgd_i,
  input logic       ref_run_i,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe_o,
  input logic [3:0] out_en_o,
  input logic       sw_mode_o,
  input logic [1:0] mode_ctl_o,
  input logic [1:0] amp_o,
  input logic [3:0] slew_o,
  input logic       fb_slew_o
);
  logic [4:0] scl_h, sda_h, rr_h;
  logic [3:0] age;
  logic       seen_pg, quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_h <= '1; sda_h <= '1; rr_h <= '0; age <= '0; seen_pg <= 1'b0;
    end else begin
      scl_h   <= {scl_h[3:0], scl_i};
      sda_h   <= {sda_h[3:0], sda_i};
      rr_h    <= {rr_h[3:0], ref_run_i};
      age     <= (age == 4'hF) ? age : age + 4'd1;
      seen_pg <= seen_pg | pwrgd_i;
    end
  end

  assign quiet = (age >= 4'd6) && (scl_h == {5{scl_i}}) && (sda_h == {5{sda_i}})
                 && (rr_h == 5'h1F) && ref_run_i;

  // R1
  no_ack_before_pg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_pg |-> !sda_oe_o);

  // R12
  idle_without_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_run_i |=> !sda_oe_o);

  // R13
  oe_quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable(sda_oe_o));

  // R13
  cfg_quiet_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable({out_en_o, sw_mode_o, mode_ctl_o, amp_o, slew_o, fb_slew_o}));

  // R13
  oe_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 4'd2) && $rose(sda_oe_o) |-> !scl_i);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrgd_i(pwrgd_i), .ref_run_i(ref_run_i),
  .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o), .out_en_o(out_en_o),
  .sw_mode_o(sw_mode_o), .mode_ctl_o(mode_ctl_o), .amp_o(amp_o),
  .slew_o(slew_o), .fb_slew_o(fb_slew_o)
);

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
  localparam int Q = 4;
  localparam logic [6:0] A_LO = 7'h6B, A_MID = 7'h6C, A_HI = 7'h6D;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, pwrgd = 1'b0, ref_run = 1'b1;
  logic [1:0] strap = 2'b00, rb = 2'b10;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] out_en, slew;
  logic       sw_mode, fb_slew;
  logic [1:0] mode_ctl, amp;
  logic       sda_line;
  assign sda_line = sda_m & ~sda_oe;

  smb_cfg_slave i_smb_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .pwrgd_i(pwrgd), .strap_i(strap), .ref_run_i(ref_run),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe), .mode_rb_i(rb),
    .out_en_o(out_en), .sw_mode_o(sw_mode), .mode_ctl_o(mode_ctl), .amp_o(amp),
    .slew_o(slew), .fb_slew_o(fb_slew)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] m [8];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [40];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2); b = sda_line; tick(Q/2); scl_m = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  // model of register images (register 1 bits [7:6] come from rb)
  task automatic model_reset();
    m[0] = 8'hFF; m[1] = 8'h02; m[2] = 8'hFF; m[3] = 8'h01;
    m[4] = 8'hFF; m[5] = 8'h01; m[6] = 8'h44; m[7] = 8'h08;
  endtask
  function automatic logic [7:0] img(input int i, input logic [7:0] old, input logic [7:0] d);
    case (i)
      0, 2: img = (d & 8'h6A) | 8'h95;
      1:    img = d & 8'h3B;
      3:    img = d & 8'h01;
      7:    img = d & 8'h1F;
      default: img = old;
    endcase
  endfunction
  function automatic logic [7:0] exp_reg(input int i);
    if (i > 7) exp_reg = 8'h00;
    else if (i == 1) exp_reg = {rb, m[1][5:0]};
    else exp_reg = m[i];
  endfunction
  function automatic logic [7:0] exp_byte(input int n, input int k);
    int c;
    c = int'(m[7][4:0]);
    if (k == 0) exp_byte = {3'b000, m[7][4:0]};
    else if (k - 1 >= c) exp_byte = 8'hFF;
    else exp_byte = exp_reg(n + k - 1);
  endfunction
  task automatic model_write(input int n, input int x, input int nsend);
    for (int k = 0; k < nsend; k++)
      if (k < x && n + k < 8) m[n+k] = img(n + k, m[n+k], wbuf[k]);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    bus_start(); send_byte({a, 1'b0}, ack); bus_stop();
  endtask
  task automatic do_write(input logic [6:0] a, input int n, input int x, input int nsend,
                          output logic ok);
    logic ak;
    ok = 1'b1;
    bus_start();
    send_byte({a, 1'b0}, ak); ok &= ak;
    if (ak) begin
      send_byte(8'(n), ak); ok &= ak;
      send_byte(8'(x), ak); ok &= ak;
      for (int k = 0; k < nsend; k++) begin send_byte(wbuf[k], ak); ok &= ak; end
    end
    bus_stop();
  endtask
  task automatic do_read(input logic [6:0] a, input int n, input int nrd, output logic ok);
    logic ak;
    logic [7:0] v;
    ok = 1'b1;
    bus_start();
    send_byte({a, 1'b0}, ak); ok &= ak;
    if (ak) begin send_byte(8'(n), ak); ok &= ak; end
    if (ok) begin
      bus_start();
      send_byte({a, 1'b1}, ak); ok &= ak;
      if (ak)
        for (int k = 0; k < nrd; k++) begin recv_byte(v, k == nrd - 1); rbuf[k] = v; end
    end
    bus_stop();
  endtask
  task automatic check_read(input string req, input logic [6:0] a, input int n, input int nrd);
    logic ok;
    do_read(a, n, nrd, ok);
    check({req, " read acks"}, 32'(ok), 32'd1);
    for (int k = 0; k < nrd; k++) check(req, {16'(n), 8'(k), rbuf[k]} , {16'(n), 8'(k), exp_byte(n, k)});
  endtask
  task automatic check_ports(input string req);
    check(req, {18'd0, out_en, sw_mode, mode_ctl, amp, slew, fb_slew},
          {18'd0, m[0][6], m[0][5], m[0][3], m[0][1], m[1][5], m[1][4:3], m[1][1:0],
           m[2][6], m[2][5], m[2][3], m[2][1], m[3][0]});
  endtask
  task automatic do_reset(input logic [1:0] s);
    rst_n = 1'b0; pwrgd = 1'b0; strap = s; tick(4); rst_n = 1'b1; tick(4);
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ok, ak;
    int n, x, ns;
    void'($urandom(32'd20240611));

    // R1: strap low
    do_reset(2'b00);
    check("R13 reset oe", 32'(sda_oe), 32'd0);
    check_ports("R7 R8 R9 reset values");
    probe(A_LO, ak); check("R1 no ack before power-good", 32'(ak), 32'd0);
    pwrgd = 1'b1; tick(4);
    probe(A_LO, ak); check("R1 strap 00 address", 32'(ak), 32'd1);
    probe(A_MID, ak); check("R1 other address ignored", 32'(ak), 32'd0);

    // R1: strap mid, later strap change ignored
    do_reset(2'b01);
    pwrgd = 1'b1; tick(4); strap = 2'b10; pwrgd = 1'b0; tick(4); pwrgd = 1'b1; tick(4);
    probe(A_MID, ak); check("R1 strap 01 address held", 32'(ak), 32'd1);
    probe(A_HI, ak); check("R1 late strap ignored", 32'(ak), 32'd0);

    // R1: strap high; rest of test on this address
    do_reset(2'b10);
    pwrgd = 1'b1; tick(4);
    probe(A_HI, ak); check("R1 strap 10 address", 32'(ak), 32'd1);

    // R4 R6 R7 R8 R9 R10: full default read
    check_read("R4 default image", A_HI, 0, 9);
    check_ports("R13 read leaves outputs");

    // R2 R3 R7: write two of three bytes
    wbuf[0] = 8'h00; wbuf[1] = 8'h3D; wbuf[2] = 8'h00;
    do_write(A_HI, 0, 2, 3, ok); model_write(0, 2, 3);
    check("R2 write acks", 32'(ok), 32'd1);
    check_ports("R2 R3 R7 R8 write effect");
    check_read("R3 extra byte ignored", A_HI, 0, 4);

    // R10: read-only registers
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    do_write(A_HI, 4, 3, 3, ok); model_write(4, 3, 3);
    check("R10 read-only write acked", 32'(ok), 32'd1);
    check_read("R10 read-only unchanged", A_HI, 4, 4);

    // R5 R6 R11: count 12 from index 4 runs past the file, then past the count
    wbuf[0] = 8'hEC; do_write(A_HI, 7, 1, 1, ok); model_write(7, 1, 1);
    check("R6 count write acked", 32'(ok), 32'd1);
    check_read("R5 R6 R11 long read", A_HI, 4, 15);

    // R5: count zero
    wbuf[0] = 8'h00; do_write(A_HI, 7, 1, 1, ok); model_write(7, 1, 1);
    check_read("R5 count zero", A_HI, 2, 3);
    wbuf[0] = 8'h08; do_write(A_HI, 7, 1, 1, ok); model_write(7, 1, 1);

    // R11: out-of-range write
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    do_write(A_HI, 9, 2, 2, ok); model_write(9, 2, 2);
    check("R11 out-of-range write acked", 32'(ok), 32'd1);
    check_read("R11 out-of-range read", A_HI, 9, 3);
    check_ports("R11 no side effect");

    // R12: reference clock stopped
    ref_run = 1'b0; tick(4);
    wbuf[0] = 8'h00;
    do_write(A_HI, 0, 1, 1, ok);
    check("R12 no ack without ref clock", 32'(ok), 32'd0);
    check_ports("R12 outputs untouched");
    ref_run = 1'b1; tick(4);

    // random traffic
    for (int it = 0; it < 20; it++) begin
      n = int'($urandom_range(0, 9));
      x = int'($urandom_range(1, 4));
      ns = x + int'($urandom_range(0, 1));
      for (int k = 0; k < ns; k++) wbuf[k] = 8'($urandom);
      for (int k = 0; k < ns; k++) if (n + k == 7) wbuf[k] = wbuf[k] & 8'h07 | 8'h04;
      rb = 2'($urandom);
      do_write(A_HI, n, x, ns, ok); model_write(n, x, ns);
      check("R2 random write acks", 32'(ok), 32'd1);
      check_ports("R7 R8 R9 random outputs");
      check_read("R4 R8 random read", A_HI, int'($urandom_range(0, 8)), 10);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule